// File: doc/BRIEF.md
# Sprite DMA Address Generator

This block forms the memory addresses for the per-scanline fetches of sprite graphics data: one byte for each of four player objects and one shared byte that holds all missile bits. A scanline scheduler pulses a slot strobe together with the slot number, and the block decides from the slot, its own line-phase state machine and the enable bits whether that slot carries a sprite fetch. For each fetch it raises a one-cycle request with a 16-bit address. The byte that memory returns is handed on to the graphics output stage with a 3-bit object tag.

Addresses are built from a base page, the resolution select and the current scanline number. Both resolutions fetch on every scanline. The double-line mode only halves the line index and packs the object areas into half the space. Vertical delay and drawing of the objects are left to the output stage.

The line-phase state machine has five states. `ST_HEAD` is the reset state and waits for the first slot 0. `ST_PLR` is the player window with the missile already fetched or disabled. `ST_PLR_DEFER` is the player window with the missile pushed to the late slot. `ST_LATE` waits for late slot 112. `ST_TAIL` is the rest of the line. The transitions are:
- `head_to_plr`: slot 0 seen in any state, list fetch not due.
- `head_to_defer`: slot 0 seen in any state, list fetch due.
- `plr_to_tail`: slot 4 seen in `ST_PLR`.
- `defer_to_late`: slot 4 seen in `ST_PLR_DEFER`.
- `late_to_tail`: slot 112 seen in `ST_LATE`.

Top module: `sprite_dma_agen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dma_req` and `obj_valid` are low.
- R2: With `plr_en` high, slot strobes 1, 2, 3 and 4 of a line each issue one fetch for player 0, 1, 2 and 3 respectively. The player number 0..3 is the object tag.
- R3: With `msl_en` high and `list_due` low at slot 0, slot 0 issues the missile fetch, tagged 4.
- R4: With `list_due` high at slot 0, slot 0 issues no fetch and the missile fetch is made at slot 112 of the same line (if `msl_en` is high). Slot 112 issues nothing when the missile was not deferred.
- R5: `plr_en` gates only player fetches and `msl_en` gates only missile fetches.
- R6: With `dbl_line` low, the address is base_page[7:3]·0x800 + offset + line_num. The offset is 0x300 for the missile and 0x400 + 0x100·n for player n.
- R7: With `dbl_line` high, the address is base_page[7:2]·0x400 + offset + line_num/2. The offset is 0x180 for the missile and 0x200 + 0x80·n for player n, so an even line and the following odd line use the same address.
- R8: Fetches happen on every scanline in both resolutions.
- R9: `dma_req` and `dma_addr` are valid in the cycle after the clock edge that samples the slot strobe. `mem_rdata` is taken in the cycle after that. `obj_valid` pulses for one cycle in the next cycle, with `obj_tag` and `obj_data`.
- R10: Slot strobes with numbers other than 0, 1–4 and 112 issue no fetch. A slot 1–4 or 112 strobe issues nothing in `ST_HEAD` or `ST_TAIL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_go | input | 1 | Slot strobe from the scanline scheduler |
| slot_num | input | 7 | Slot number qualified by `slot_go` |
| list_due | input | 1 | A list instruction fetch owns slot 0 on this line |
| plr_en | input | 1 | Player fetch enable |
| msl_en | input | 1 | Missile fetch enable |
| dbl_line | input | 1 | 1 = double-line resolution |
| base_page | input | 8 | High byte of the sprite area base |
| line_num | input | 8 | Current scanline number |
| mem_rdata | input | 8 | Memory byte, valid the cycle after a request |
| dma_req | output | 1 | Fetch request, one cycle |
| dma_addr | output | 16 | Fetch address |
| obj_valid | output | 1 | Returned byte strobe, one cycle |
| obj_tag | output | 3 | Object tag: 0–3 players, 4 missile |
| obj_data | output | 8 | Returned byte |

## Verification
A request is due one cycle after the edge that samples its slot strobe. The tagged byte is due two cycles after the request. The driver queues the expected address and the expected tag/data pair for a slot before it pulses that slot. The monitor samples on the falling edge and pops one entry from the request queue for every cycle with `dma_req` high, and one entry from the output queue for every cycle with `obj_valid` high. Because of this, an early, late, missing or extra item shows up either as a mismatch or as an empty queue. After each line the bench waits past the longest latency and checks that both queues have drained.

// File: rtl/spdma_pkg.sv
package spdma_pkg;
    localparam int TAG_W   = 3;
    localparam int PAGE_W  = 8;
    localparam int LINE_W  = 8;
    localparam int ADDR_W  = PAGE_W + LINE_W;
    localparam int DATA_W  = 8;
    localparam int SLOT_W  = 7;
    localparam int N_PLR   = 4;

    localparam logic [TAG_W-1:0] TAG_MSL = 3'd4;

    typedef enum logic [2:0] {
        ST_HEAD,
        ST_PLR,
        ST_PLR_DEFER,
        ST_LATE,
        ST_TAIL
    } line_phase_t;
endpackage

// File: rtl/spdma_slot_fsm.sv
module spdma_slot_fsm
    import spdma_pkg::*;
#(
    parameter int SW        = SLOT_W,
    parameter int LATE_SLOT = 112,
    parameter int PLAYERS   = N_PLR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_go,
    input  logic [SW-1:0]     slot_num,
    input  logic              list_due,
    input  logic              plr_en,
    input  logic              msl_en,
    output logic              fetch_go,
    output logic [TAG_W-1:0]  fetch_tag
);
    localparam logic [SW-1:0] SLOT_FIRST_PLR = SW'(1);
    localparam logic [SW-1:0] SLOT_LAST_PLR  = SW'(PLAYERS);
    localparam logic [SW-1:0] SLOT_LATE      = SW'(LATE_SLOT);

    line_phase_t st, st_nxt;

    logic in_plr_win;
    assign in_plr_win = (slot_num >= SLOT_FIRST_PLR) && (slot_num <= SLOT_LAST_PLR);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HEAD;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt    = st;
        fetch_go  = 1'b0;
        fetch_tag = TAG_MSL;
        if (slot_go) begin
            if (slot_num == '0) begin
                fetch_go = msl_en && !list_due;
                st_nxt   = list_due ? ST_PLR_DEFER : ST_PLR;
            end else begin
                unique case (st)
                    ST_PLR, ST_PLR_DEFER: begin
                        if (in_plr_win) begin
                            fetch_go  = plr_en;
                            fetch_tag = TAG_W'(slot_num - SLOT_FIRST_PLR);
                            if (slot_num == SLOT_LAST_PLR)
                                st_nxt = (st == ST_PLR_DEFER) ? ST_LATE : ST_TAIL;
                        end
                    end
                    ST_LATE: begin
                        if (slot_num == SLOT_LATE) begin
                            fetch_go = msl_en;
                            st_nxt   = ST_TAIL;
                        end
                    end
                    ST_HEAD, ST_TAIL: begin
                        st_nxt = st;
                    end
                    default: st_nxt = ST_HEAD;
                endcase
            end
        end
    end

    // R10: outside the player window and the late slot, nothing but slot 0 fetches
    p_quiet_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TAIL || st == ST_HEAD) && slot_num != '0 |-> !fetch_go);
    // R4: a deferral always ends in the late state once slot 4 is passed
    p_defer_to_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_PLR_DEFER && slot_go && slot_num == SLOT_LAST_PLR |=> st == ST_LATE);
endmodule

// File: rtl/spdma_addr_calc.sv
module spdma_addr_calc
    import spdma_pkg::*;
(
    input  logic              dbl_line,
    input  logic [PAGE_W-1:0] base_page,
    input  logic [LINE_W-1:0] line_num,
    input  logic [TAG_W-1:0]  tag,
    output logic [ADDR_W-1:0] addr
);
    localparam int SGL_BASE_W = ADDR_W - 3 - LINE_W;
    localparam int DBL_BASE_W = ADDR_W - 3 - (LINE_W - 1);

    logic [2:0] sgl_field, dbl_field;
    logic [ADDR_W-1:0] sgl_addr, dbl_addr;

    always_comb begin
        if (tag == TAG_MSL) begin
            sgl_field = 3'b011;
            dbl_field = 3'b011;
        end else begin
            sgl_field = {1'b1, tag[1:0]};
            dbl_field = {1'b1, tag[1:0]};
        end
    end

    assign sgl_addr = {base_page[PAGE_W-1 -: SGL_BASE_W], sgl_field, line_num};
    assign dbl_addr = {base_page[PAGE_W-1 -: DBL_BASE_W], dbl_field, line_num[LINE_W-1:1]};
    assign addr     = dbl_line ? dbl_addr : sgl_addr;
endmodule

// File: rtl/spdma_return.sv
module spdma_return
    import spdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              obj_valid,
    output logic [TAG_W-1:0]  obj_tag,
    output logic [DATA_W-1:0] obj_data
);
    logic             pend;
    logic [TAG_W-1:0] pend_tag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_tag  <= '0;
            obj_valid <= 1'b0;
            obj_tag   <= '0;
            obj_data  <= '0;
        end else begin
            pend      <= req;
            pend_tag  <= req_tag;
            obj_valid <= pend;
            if (pend) begin
                obj_tag  <= pend_tag;
                obj_data <= mem_rdata;
            end
        end
    end

    // R9: each returned byte follows its request by exactly two cycles
    p_req_to_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ##1 obj_valid);
    p_valid_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        obj_valid |-> $past(req, 2));
endmodule

// File: rtl/sprite_dma_agen.sv
module sprite_dma_agen
    import spdma_pkg::*;
#(
    parameter int LATE_SLOT = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_go,
    input  logic [6:0]        slot_num,
    input  logic              list_due,
    input  logic              plr_en,
    input  logic              msl_en,
    input  logic              dbl_line,
    input  logic [7:0]        base_page,
    input  logic [7:0]        line_num,
    input  logic [7:0]        mem_rdata,
    output logic              dma_req,
    output logic [15:0]       dma_addr,
    output logic              obj_valid,
    output logic [2:0]        obj_tag,
    output logic [7:0]        obj_data
);
    logic             fetch_go;
    logic [TAG_W-1:0] fetch_tag;
    logic [ADDR_W-1:0] next_addr;
    logic [TAG_W-1:0] req_tag;

    spdma_slot_fsm #(.SW(SLOT_W), .LATE_SLOT(LATE_SLOT), .PLAYERS(N_PLR)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_go   (slot_go),
        .slot_num  (slot_num),
        .list_due  (list_due),
        .plr_en    (plr_en),
        .msl_en    (msl_en),
        .fetch_go  (fetch_go),
        .fetch_tag (fetch_tag)
    );

    spdma_addr_calc calc_i (
        .dbl_line  (dbl_line),
        .base_page (base_page),
        .line_num  (line_num),
        .tag       (fetch_tag),
        .addr      (next_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req  <= 1'b0;
            dma_addr <= '0;
            req_tag  <= '0;
        end else begin
            dma_req <= fetch_go;
            if (fetch_go) begin
                dma_addr <= next_addr;
                req_tag  <= fetch_tag;
            end
        end
    end

    spdma_return ret_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (dma_req),
        .req_tag   (req_tag),
        .mem_rdata (mem_rdata),
        .obj_valid (obj_valid),
        .obj_tag   (obj_tag),
        .obj_data  (obj_data)
    );

    // R5: each enable gates its own object class
    p_player_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && req_tag != TAG_MSL |-> $past(plr_en));
    p_missile_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && req_tag == TAG_MSL |-> $past(msl_en));
    // R6: single-line addresses keep the upper five base bits
    p_single_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !$past(dbl_line) |-> dma_addr[15:11] == $past(base_page[7:3]));
    // R7: double-line addresses keep the upper six base bits
    p_double_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && $past(dbl_line) |-> dma_addr[15:10] == $past(base_page[7:2]));
    // R9: requests are single-cycle pulses per slot strobe
    p_req_from_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(slot_go));
endmodule

// File: tb/sprite_dma_agen_tb_top.sv
module sprite_dma_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_go = 1'b0;
    logic [6:0]  slot_num = '0;
    logic        list_due = 1'b0;
    logic        plr_en = 1'b0;
    logic        msl_en = 1'b0;
    logic        dbl_line = 1'b0;
    logic [7:0]  base_page = '0;
    logic [7:0]  line_num = '0;
    logic [7:0]  mem_rdata = '0;
    logic        dma_req;
    logic [15:0] dma_addr;
    logic        obj_valid;
    logic [2:0]  obj_tag;
    logic [7:0]  obj_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] exp_addr_q[$];
    logic [10:0] exp_obj_q[$];

    always #5 clk = ~clk;

    sprite_dma_agen dut_i (
        .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .slot_num(slot_num),
        .list_due(list_due), .plr_en(plr_en), .msl_en(msl_en), .dbl_line(dbl_line),
        .base_page(base_page), .line_num(line_num), .mem_rdata(mem_rdata),
        .dma_req(dma_req), .dma_addr(dma_addr), .obj_valid(obj_valid),
        .obj_tag(obj_tag), .obj_data(obj_data)
    );

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory answers one cycle after a request
    always @(posedge clk) mem_rdata <= dma_req ? mem_fn(dma_addr) : 8'h00;

    function automatic logic [15:0] exp_addr(input int obj, input bit db,
                                             input logic [7:0] b, input logic [7:0] ln);
        int a;
        if (!db) a = (int'(b) / 8) * 2048 + ((obj == 4) ? 'h300 : 'h400 + 'h100 * obj) + int'(ln);
        else     a = (int'(b) / 4) * 1024 + ((obj == 4) ? 'h180 : 'h200 + 'h80 * obj) + int'(ln) / 2;
        return a[15:0];
    endfunction

    task automatic push_exp(input int obj);
        logic [15:0] a;
        a = exp_addr(obj, dbl_line, base_page, line_num);
        exp_addr_q.push_back(a);
        exp_obj_q.push_back({3'(obj), mem_fn(a)});
    endtask

    task automatic strobe(input int s);
        @(negedge clk);
        slot_go  = 1'b1;
        slot_num = 7'(s);
        @(negedge clk);
        slot_go  = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare against the scoreboard away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dma_req) begin
                if (exp_addr_q.size() == 0) check(0, "R10 unexpected request", dma_addr, 0);
                else begin
                    logic [15:0] e;
                    e = exp_addr_q.pop_front();
                    check(dma_addr == e, "R6 R7 address", dma_addr, e);
                end
            end
            if (obj_valid) begin
                if (exp_obj_q.size() == 0) check(0, "R9 unexpected byte", {obj_tag, obj_data}, 0);
                else begin
                    logic [10:0] e;
                    e = exp_obj_q.pop_front();
                    check({obj_tag, obj_data} == e, "R2 R3 R9 tag/data", {obj_tag, obj_data}, e);
                end
            end
        end
    end

    // one scanline: slots 0..4, an unused slot, then the late slot
    task automatic run_line(input logic [7:0] ln, input bit ld, input bit pe,
                            input bit me, input bit db, input logic [7:0] b);
        @(negedge clk);
        line_num = ln; list_due = ld; plr_en = pe; msl_en = me; dbl_line = db; base_page = b;
        if (me && !ld) push_exp(4);                // R3
        strobe(0);
        for (int p = 0; p < 4; p++) begin
            if (pe) push_exp(p);                   // R2
            strobe(p + 1);
        end
        strobe(60);                                // R10: ignored
        strobe(5);                                 // R10: ignored
        if (me && ld) push_exp(4);                 // R4
        strobe(112);
        strobe(112);                               // R10: second late strobe in ST_TAIL
        repeat (4) @(negedge clk);
        check(exp_addr_q.size() == 0 && exp_obj_q.size() == 0,
              "R8 R4 queues drained at end of line", exp_addr_q.size() + exp_obj_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dma_req == 0 && obj_valid == 0, "R1 reset outputs", {dma_req, obj_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dma_req == 0 && obj_valid == 0, "R1 after reset", {dma_req, obj_valid}, 0);
        // R10: player and late slots before any slot 0 are ignored (ST_HEAD)
        plr_en = 1; msl_en = 1;
        strobe(1); strobe(112);
        repeat (3) @(negedge clk);
        check(exp_addr_q.size() == 0, "R10 head state idle", exp_addr_q.size(), 0);
        // single-line resolution, R6
        run_line(8'd0,   0, 1, 1, 0, 8'hA8);
        run_line(8'd5,   0, 1, 1, 0, 8'h3F);
        run_line(8'd255, 1, 1, 1, 0, 8'hF0);   // R4 deferred missile
        run_line(8'd9,   1, 1, 0, 0, 8'h10);   // R5 missile off while deferred
        run_line(8'd10,  0, 0, 1, 0, 8'h20);   // R5 players off
        run_line(8'd11,  0, 1, 0, 0, 8'h20);   // R5 missile off
        run_line(8'd12,  0, 0, 0, 0, 8'h20);   // R5 both off
        // double-line resolution, R7 and R8: consecutive even/odd lines
        run_line(8'd6,   0, 1, 1, 1, 8'hA8);
        run_line(8'd7,   0, 1, 1, 1, 8'hA8);
        run_line(8'd255, 1, 1, 1, 1, 8'h7C);
        run_line(8'd128, 1, 0, 1, 1, 8'hFF);
        run_line(8'd1,   0, 1, 1, 1, 8'h03);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule